// File: doc/BRIEF.md
# Second-Level Interrupt Event Collector

The collector merges a large set of numbered platform event lines into one level-sensitive interrupt request for a processor. There are 169 event numbers, 0 to 168. Numbers 0–159 come from hardware lines. Numbers 36–111 are reserved and can never fire. Numbers 160–167 are raised by software through a register write. Number 168 fires on each rising edge of an already synchronised reference-clock input. Every event number has its own enable bit. An enabled event is latched as pending and then moved, as its 8-bit number, into a 16-entry first-in-first-out queue.

The interrupt output stays high while the queue holds at least one number. The service routine reads the pop register again and again until the line drops. When several events are accepted in the same cycle, the lowest number is queued first, one per cycle. When the queue is full, accepted events wait in their pending latches and a sticky overflow flag records the condition.

Top module: `evc_collector`

## Requirements
- R1: A hardware line (0–35, 112–159) raises its event only on a low-to-high change between consecutive clock samples. A line held high raises it once.
- R2: All enable bits reset to zero. Register word k (address k, 0..5) bit b enables event 32k+b, and is readable and writable. An event whose enable bit is clear is dropped and never queued.
- R3: Hardware lines 36–111 are reserved and never produce a queued event, whatever their enable bits are.
- R4: A write to address 6 raises event 160+i for every set bit i of write data bits [7:0].
- R5: A rising edge of the reference input raises event 168.
- R6: The irq output is high exactly while the queue is non-empty. An input rise sampled at clock edge E gives irq high after edge E+1, not earlier.
- R7: A read of address 7 returns {1'b1, 23'b0, id[7:0]} of the oldest entry and removes that entry at the clock edge. If the queue is empty, the read returns 0.
- R8: Events accepted in the same cycle are queued one per cycle in ascending number order.
- R9: The queue holds 16 entries and keeps arrival order. Accepted events that find it full stay pending and are queued later as space frees, lowest pending number first.
- R10: Status (address 8) bit 0 is a sticky overflow flag. It is set when any event is accepted while the queue is full, and a write of 1 to bit 0 clears it. Bits [12:8] give the queue occupancy.
- R11: After reset, irq is low, the status register reads 0 and a pop read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | 160 | Hardware event lines, numbers 0–159 |
| ref_in | input | 1 | Synchronised reference-clock level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 7 pops) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Level interrupt request, high while the queue is non-empty |

## Verification
The assertions take for granted that the event and reference inputs are already synchronous to clk, and that read and write strobes are never asserted together. They also assume a pop strobe only comes from the processor, so a fall of irq always follows a pop. The stimulus changes inputs only at the falling edge and keeps every line low through reset. It uses single-strobe bus cycles, and it fills the queue through many lines rising together, which drives the full and overflow paths without violating these assumptions.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int EVC_HW_LINES = 160;
  localparam int EVC_SW_LINES = 8;
  localparam int EVC_RSV_LO   = 36;
  localparam int EVC_RSV_HI   = 111;
  localparam int EVC_DEPTH    = 16;
  localparam int EVC_IDW      = 8;
  localparam int EVC_ADDR_W   = 4;

  function automatic int evc_words(input int nbits);
    return (nbits + 31) / 32;
  endfunction

  function automatic bit evc_reserved(input int id, input int lo, input int hi);
    return (id >= lo) && (id <= hi);
  endfunction
endpackage

// File: rtl/evc_trigger.sv
module evc_trigger #(
  parameter int N_HW   = 160,
  parameter int N_SW   = 8,
  parameter int RSV_LO = 36,
  parameter int RSV_HI = 111,
  localparam int N     = N_HW + N_SW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HW-1:0] hw_evt,
  input  logic [N_SW-1:0] sw_evt,
  input  logic            ref_in,
  input  logic [N-1:0]    en,
  output logic [N-1:0]    accept
);
  logic [N_HW-1:0] prev_q;
  logic            ref_prev_q;
  logic [N_HW-1:0] hw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      ref_prev_q <= 1'b0;
    end else begin
      prev_q     <= hw_evt;
      ref_prev_q <= ref_in;
    end
  end

  for (genvar g = 0; g < N_HW; g++) begin : g_line
    if (evc_pkg::evc_reserved(g, RSV_LO, RSV_HI)) begin : g_rsv
      assign hw_rise[g] = 1'b0;
    end else begin : g_live
      assign hw_rise[g] = hw_evt[g] & ~prev_q[g];
    end
  end

  assign accept = {ref_in & ~ref_prev_q, sw_evt, hw_rise} & en;
endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter #(
  parameter int N   = 169,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   accept,
  input  logic           space,
  output logic [N-1:0]   pend,
  output logic           grant_vld,
  output logic [IDW-1:0] grant_id,
  output logic [N-1:0]   grant_vec
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [IDW-1:0] lowest(input logic [N-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDW'(i);
    end
    return r;
  endfunction

  logic [N-1:0] pend_q;

  assign pend      = pend_q;
  assign grant_vld = space & (|pend_q);
  assign grant_id  = lowest(pend_q);
  assign grant_vec = grant_vld ? (ONE << grant_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant_vec) | accept;
  end
endmodule

// File: rtl/evc_fifo.sv
module evc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic            full,
  output logic            empty,
  output logic [CNTW-1:0] cnt
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [CNTW-1:0] cnt_q;

  assign head  = mem[rptr_q];
  assign cnt   = cnt_q;
  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/evc_collector.sv
module evc_collector #(
  parameter int N_HW   = evc_pkg::EVC_HW_LINES,
  parameter int N_SW   = evc_pkg::EVC_SW_LINES,
  parameter int RSV_LO = evc_pkg::EVC_RSV_LO,
  parameter int RSV_HI = evc_pkg::EVC_RSV_HI,
  parameter int DEPTH  = evc_pkg::EVC_DEPTH,
  parameter int IDW    = evc_pkg::EVC_IDW,
  parameter int ADDR_W = evc_pkg::EVC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_evt,
  input  logic              ref_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int N        = N_HW + N_SW + 1;
  localparam int EN_WORDS = evc_pkg::evc_words(N);
  localparam int CNTW     = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_SWEV = ADDR_W'(EN_WORDS);
  localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(EN_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(EN_WORDS + 2);

  logic [N-1:0]          en_q;
  logic                  ovf_q;
  logic [N-1:0]          accept;
  logic [N-1:0]          pend;
  logic [N-1:0]          grant_vec;
  logic [IDW-1:0]        grant_id;
  logic [IDW-1:0]        head;
  logic [CNTW-1:0]       cnt;
  logic [N_SW-1:0]       sw_evt;
  logic [EN_WORDS*32-1:0] en_pad;
  logic                  push, pop_fire, full, empty, accept_any, ovf_clr;

  assign sw_evt     = (bus_wr && bus_addr == A_SWEV) ? bus_wdata[N_SW-1:0] : '0;
  assign accept_any = |accept;
  assign pop_fire   = bus_rd && (bus_addr == A_POP) && !empty;
  assign ovf_clr    = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];
  assign irq        = !empty;
  assign en_pad     = (EN_WORDS*32)'(en_q);

  evc_trigger #(.N_HW(N_HW), .N_SW(N_SW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_trig (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_evt(sw_evt),
    .ref_in(ref_in), .en(en_q), .accept(accept)
  );

  evc_arbiter #(.N(N), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .accept(accept), .space(!full), .pend(pend),
    .grant_vld(push), .grant_id(grant_id), .grant_vec(grant_vec)
  );

  evc_fifo #(.DEPTH(DEPTH), .W(IDW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(grant_id), .pop(pop_fire),
    .head(head), .full(full), .empty(empty), .cnt(cnt)
  );

  for (genvar g = 0; g < N; g++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[g] <= 1'b0;
      else if (bus_wr && bus_addr == ADDR_W'(g / 32)) en_q[g] <= bus_wdata[g % 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (accept_any && full) ovf_q <= 1'b1;
    else if (ovf_clr)            ovf_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (int'(bus_addr) < EN_WORDS)
        bus_rdata = en_pad[int'(bus_addr)*32 +: 32];
      else if (bus_addr == A_POP && !empty)
        bus_rdata = {1'b1, {(31-IDW){1'b0}}, head};
      else if (bus_addr == A_STAT)
        bus_rdata = (32'(cnt) << 8) | 32'(ovf_q);
    end
  end
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int N      = 169,
  parameter int DEPTH  = 16,
  parameter int CNTW   = 5,
  parameter int RSV_LO = 36,
  parameter int RSV_HI = 111
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            pop_fire,
  input logic            push,
  input logic            full,
  input logic            accept_any,
  input logic            ovf_q,
  input logic [CNTW-1:0] cnt,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    grant_vec,
  input logic [31:0]     bus_rdata
);
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(pop_fire));
  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));
  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_any && full) |=> ovf_q);
  // R3
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[RSV_HI:RSV_LO] == '0);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  // R7
  pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> bus_rdata[31]);
endmodule

bind evc_collector evc_checker #(
  .N(N), .DEPTH(DEPTH), .CNTW(CNTW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pop_fire(pop_fire), .push(push),
  .full(full), .accept_any(accept_any), .ovf_q(ovf_q), .cnt(cnt),
  .pend(pend), .grant_vec(grant_vec), .bus_rdata(bus_rdata)
);

// File: tb/sim_evc_collector.sv
module sim_evc_collector;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] hw_evt = '0;
  logic         ref_in = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit m_en   [169];
  bit m_pend [169];
  bit m_prev [160];
  bit m_refp;
  bit m_ovf;
  int q[$];

  evc_collector u0 (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .ref_in(ref_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] r = '0;
    if (a < 6) begin
      for (int b = 0; b < 32; b++) if (32*a + b < 169) r[b] = m_en[32*a + b];
    end else if (a == 7) begin
      if (q.size() > 0) r = 32'h8000_0000 | 32'(q[0]);
    end else if (a == 8) begin
      r = (32'(q.size()) << 8) | 32'(m_ovf);
    end
    return r;
  endfunction

  function automatic void m_reset();
    foreach (m_en[i])   m_en[i] = 0;
    foreach (m_pend[i]) m_pend[i] = 0;
    foreach (m_prev[i]) m_prev[i] = 0;
    m_refp = 0; m_ovf = 0; q.delete();
  endfunction

  function automatic void m_step();
    bit acc [169];
    bit any = 0;
    int gid = -1;
    for (int i = 0; i < 160; i++)
      acc[i] = hw_evt[i] && !m_prev[i] && !(i >= 36 && i <= 111) && m_en[i];
    for (int i = 0; i < 8; i++)
      acc[160+i] = bus_wr && bus_addr == 6 && bus_wdata[i] && m_en[160+i];
    acc[168] = ref_in && !m_refp && m_en[168];
    foreach (acc[i]) any |= acc[i];
    if (q.size() < 16)
      for (int i = 168; i >= 0; i--) if (m_pend[i]) gid = i;
    if (any && q.size() == 16) m_ovf = 1;
    else if (bus_wr && bus_addr == 8 && bus_wdata[0]) m_ovf = 0;
    if (bus_rd && bus_addr == 7 && q.size() > 0) void'(q.pop_front());
    if (gid >= 0) begin q.push_back(gid); m_pend[gid] = 0; end
    foreach (acc[i]) if (acc[i]) m_pend[i] = 1;
    if (bus_wr && bus_addr < 6)
      for (int b = 0; b < 32; b++) if (32*bus_addr + b < 169) m_en[32*bus_addr + b] = bus_wdata[b];
    for (int i = 0; i < 160; i++) m_prev[i] = hw_evt[i];
    m_refp = ref_in;
  endfunction

  // one clock: inputs set at the falling edge, read data checked before the rise
  task automatic cycle(input string tag);
    #1;
    if (bus_rd) check(bus_rdata === m_read(int'(bus_addr)), tag, bus_rdata, m_read(int'(bus_addr)));
    m_step();
    @(posedge clk);
    @(negedge clk);
    check(irq === (q.size() != 0), "R6 irq level", 32'(irq), 32'(q.size() != 0));
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle("idle");
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    cycle("write");
  endtask

  task automatic rd(input int a, input string tag);
    bus_rd = 1; bus_addr = 4'(a);
    cycle(tag);
  endtask

  task automatic pop_expect(input int id, input string tag);
    bus_rd = 1; bus_addr = 4'd7;
    #1;
    check(bus_rdata === (32'h8000_0000 | 32'(id)), tag, bus_rdata, 32'h8000_0000 | 32'(id));
    cycle(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(irq === 1'b0, "R11 irq after reset", 32'(irq), 0);
    for (int a = 0; a < 6; a++) rd(a, "R2 enable reset");
    rd(8, "R11 status reset");
    rd(7, "R7 pop on empty");

    // R2 disabled event dropped
    hw_evt[5] = 1; idle(3);
    check(irq === 1'b0, "R2 disabled no irq", 32'(irq), 0);
    rd(7, "R2 nothing queued");
    hw_evt[5] = 0;

    // R1 R6 R8 simultaneous rises, ascending order
    wr(0, 32'h4000_002A);
    rd(0, "R2 enable readback");
    hw_evt[1] = 1; hw_evt[3] = 1; hw_evt[30] = 1;
    cycle("R6 first edge");
    check(irq === 1'b0, "R6 irq not before second edge", 32'(irq), 0);
    cycle("R6 second edge");
    check(irq === 1'b1, "R6 irq after second edge", 32'(irq), 1);
    idle(4);
    pop_expect(1, "R8 first lowest");
    pop_expect(3, "R8 second");
    pop_expect(30, "R8 third");
    idle(2);
    rd(7, "R1 held level no repeat");
    check(irq === 1'b0, "R1 irq low with lines held", 32'(irq), 0);
    hw_evt[1] = 0; hw_evt[3] = 0; hw_evt[30] = 0;
    idle(1);

    // R3 reserved lines
    wr(1, 32'hFFFF_FFFF);
    hw_evt[50] = 1; hw_evt[33] = 1; idle(3);
    pop_expect(33, "R3 live line queued");
    rd(7, "R3 reserved not queued");
    hw_evt[50] = 0; hw_evt[33] = 0;

    // R4 software events
    wr(5, 32'h0000_01FF);
    wr(6, 32'h0000_0081);
    idle(2);
    pop_expect(160, "R4 sw bit0");
    pop_expect(167, "R4 sw bit7");

    // R5 reference clock rise
    ref_in = 1; idle(3);
    pop_expect(168, "R5 ref rise");
    ref_in = 0; idle(1); ref_in = 1; idle(2);
    pop_expect(168, "R5 second ref rise");
    ref_in = 0;

    // R9 arrival order across cycles
    wr(3, 32'h0008_0000);
    wr(4, 32'h0000_1000);
    hw_evt[140] = 1; cycle("arrive 140");
    hw_evt[115] = 1; idle(3);
    pop_expect(140, "R9 arrival order first");
    pop_expect(115, "R9 arrival order second");
    hw_evt[140] = 0; hw_evt[115] = 0;
    idle(1);

    // R9 R10 full queue and overflow
    wr(4, 32'hFFFF_FFFF);
    hw_evt[159:128] = '1;
    idle(20);
    rd(8, "R9 occupancy full no overflow");
    hw_evt[128] = 0; idle(1);
    hw_evt[128] = 1; idle(1);
    rd(8, "R10 overflow set");
    wr(8, 32'h1);
    rd(8, "R10 overflow cleared");
    for (int i = 128; i < 144; i++) pop_expect(i, "R9 drain first block");
    pop_expect(128, "R9 pending re-raise");
    for (int i = 144; i < 160; i++) pop_expect(i, "R9 drain held pending");
    idle(2);
    rd(7, "R7 empty after drain");
    check(irq === 1'b0, "R6 irq low after drain", 32'(irq), 0);
    hw_evt = '0;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule